// File: doc/BRIEF.md
# Radix-2^2 Feedback Butterfly Pair

This block is the repeating unit of a streaming, pipelined FFT. Complex samples enter one per clock, and frames of `N` samples follow one another with no gap. The unit contains two cascaded radix-2 butterflies, and each butterfly owns a feedback shift register. The first butterfly's register is `N/2` deep. The second butterfly's register is `N/4` deep. The unit reaches the multiplier count of a radix-4 stage while keeping radix-2 hardware. The only rotation it needs is a multiplication by -j. That rotation is done by swapping the real and imaginary parts and negating one of them.

Each butterfly works in two phases. In the first half of its period it only fills its delay line. While it fills, it emits the differences it wrote back during the previous period. In the second half it adds each incoming sample to the stored one and sends the sum forward. In the same cycle it stores the difference in place of the stored sample. Because of this, a new frame can be loaded while the previous frame drains, and the stream never stalls. Every butterfly output is registered. The data path grows by one bit per butterfly and applies no scaling or rounding.

A full FFT would follow this unit with a general twiddle multiplier and further units. The transform leaves that pipeline in bit-reversed order.

Top module: `r22_sdf_stage`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_re`, `out_im` and `frame_cnt` are all zero, whatever the input ports carry.
- R2: `frame_cnt` increments by one, modulo `N`, on every clock edge where `in_valid` is high. It holds its value on every edge where `in_valid` is low.
- R3: With `in_valid` high on every cycle from reset, `out_valid` first rises on the clock edge that follows the capture of input number `3N/4` (counting from zero). That is `3N/4+1` edges after the first sample is captured. Before that edge it is low.
- R4: After the pipeline has primed, `out_valid` repeats `in_valid` with a delay of two cycles. Idle input cycles remove no samples and reorder none. They insert idle output cycles instead.
- R5: Let a frame be `x[0..N-1]` and let `Q = N/4`. Number the output samples of that frame `o = g*Q + k`, where `g` is 0..3 and `k` is 0..Q-1. Output `o` equals `c0*x[k] + c1*x[k+Q] + c2*x[k+2Q] + c3*x[k+3Q]`. The coefficients `(c0,c1,c2,c3)` are `(1,1,1,1)` for `g=0`, `(1,-1,1,-1)` for `g=1`, `(1,-j,-1,+j)` for `g=2`, and `(1,+j,-1,-j)` for `g=3`.
- R6: Consecutive frames are processed back to back. The output of frame `F+1` starts on the cycle after the last output of frame `F`, and every frame meets R5.
- R7: Inputs are 12-bit signed two's complement, and outputs are 14-bit signed. Results are exact for all input values, including `-8192` when all four terms are `-2048`. There is no saturation, rounding or scaling.
- R8: The value fed to the -j rotation is never the most negative code of its width. Because of this, the swap-and-negate cannot wrap, and rotated terms stay exact when the inputs are at full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present this cycle |
| in_re | input | 12 | Input real part, signed |
| in_im | input | 12 | Input imaginary part, signed |
| out_valid | output | 1 | Output sample present this cycle |
| out_re | output | 14 | Output real part, signed |
| out_im | output | 14 | Output imaginary part, signed |
| frame_cnt | output | 4 | Position of the next input sample within its frame |

## Verification
A single complex impulse at the start of a frame should appear once in each of the four output groups. This tests the group ordering and the latency to the first valid output. A constant frame may produce energy only in group 0. If any other group carries a value, a butterfly's sum and difference paths have been swapped. A sparse frame puts real values in one quarter and imaginary values in another. It separates a correct -j from +j and from a missing rotation. Full-scale frames exercise the bit growth and the rotation at its limits. Pseudo-random frames run back to back and then again with idle gaps, which shows that frame boundaries and stalls do not disturb the delay-line phases.

// File: rtl/r22_pkg.sv
`timescale 1ns/1ps
package r22_pkg;
  // Phase of one feedback butterfly within its period
  typedef enum logic {
    PH_FILL  = 1'b0,  // store incoming, emit fed-back difference
    PH_MERGE = 1'b1   // emit sum, write difference back
  } phase_e;
endpackage

// File: rtl/r22_ctrl.sv
`timescale 1ns/1ps
module r22_ctrl
  import r22_pkg::*;
#(
  parameter int FRAME = 16,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(FRAME),
  localparam int HB = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic [CW-1:0] cnt,
  output phase_e        phase,
  output logic          late_quarter,
  output logic          primed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      primed <= 1'b0;
    end else if (in_valid) begin
      cnt <= cnt + 1'b1;
      if (phase == PH_MERGE) primed <= 1'b1;
    end
  end

  assign phase        = cnt[HB] ? PH_MERGE : PH_FILL;
  assign late_quarter = cnt[CW-1] & cnt[CW-2];

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (cnt == CW'($past(cnt) + 1'b1)));
  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt));
  assert_primed_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> primed);
endmodule

// File: rtl/r22_delay_line.sv
`timescale 1ns/1ps
module r22_delay_line #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic signed [W-1:0] din_re,
  input  logic signed [W-1:0] din_im,
  output logic signed [W-1:0] dout_re,
  output logic signed [W-1:0] dout_im
);
  logic signed [W-1:0] tap_re [DEPTH];
  logic signed [W-1:0] tap_im [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        tap_re[i] <= '0;
        tap_im[i] <= '0;
      end
    end else if (shift_en) begin
      tap_re[0] <= din_re;
      tap_im[0] <= din_im;
      for (int i = 1; i < DEPTH; i++) begin
        tap_re[i] <= tap_re[i-1];
        tap_im[i] <= tap_im[i-1];
      end
    end
  end

  assign dout_re = tap_re[DEPTH-1];
  assign dout_im = tap_im[DEPTH-1];
endmodule

// File: rtl/r22_bf_unit.sv
`timescale 1ns/1ps
module r22_bf_unit
  import r22_pkg::*;
#(
  parameter int FRAME = 16,
  parameter int DEPTH = 8,
  parameter int IW    = 12,
  parameter bit ROT   = 1'b0,
  localparam int OW = IW + 1,
  localparam int CW = $clog2(FRAME)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] in_re,
  input  logic signed [IW-1:0] in_im,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_re,
  output logic signed [OW-1:0] out_im,
  output logic [CW-1:0]        cnt,
  output logic                 primed
);
  // arithmetic kept in functions so the bench can restate it independently
  function automatic logic signed [OW-1:0] widen(input logic signed [IW-1:0] v);
    return OW'(v);
  endfunction
  function automatic logic signed [OW-1:0] negate(input logic signed [OW-1:0] v);
    return -v;
  endfunction

  phase_e phase;
  logic   late_quarter;
  logic   merge_phase;   // named event: combining half of the period
  logic   rot_active;    // named event: -j applied to this sample
  logic signed [OW-1:0] x_re, x_im, head_re, head_im;
  logic signed [OW-1:0] sum_re, sum_im, dif_re, dif_im;
  logic signed [OW-1:0] wb_re, wb_im, nxt_re, nxt_im;

  r22_ctrl #(.FRAME(FRAME), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cnt(cnt),
    .phase(phase), .late_quarter(late_quarter), .primed(primed)
  );

  assign merge_phase = (phase == PH_MERGE);
  assign rot_active  = ROT && late_quarter;

  always_comb begin
    if (rot_active) begin
      x_re = widen(in_im);
      x_im = negate(widen(in_re));
    end else begin
      x_re = widen(in_re);
      x_im = widen(in_im);
    end
    sum_re = head_re + x_re;
    sum_im = head_im + x_im;
    dif_re = head_re - x_re;
    dif_im = head_im - x_im;
    wb_re  = merge_phase ? dif_re : x_re;
    wb_im  = merge_phase ? dif_im : x_im;
    nxt_re = merge_phase ? sum_re : head_re;
    nxt_im = merge_phase ? sum_im : head_im;
  end

  r22_delay_line #(.DEPTH(DEPTH), .W(OW)) u_dly (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid),
    .din_re(wb_re), .din_im(wb_im), .dout_re(head_re), .dout_im(head_im)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= in_valid && (primed || merge_phase);
      if (in_valid) begin
        out_re <= nxt_re;
        out_im <= nxt_im;
      end
    end
  end

  assert_valid_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> (out_valid == $past(in_valid)));
  assert_fill_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!primed && !merge_phase) |=> !out_valid);

  generate
    if (ROT) begin : g_rot_check
      localparam logic signed [IW-1:0] MOST_NEG = {1'b1, {(IW-1){1'b0}}};
      assert_rot_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rot_active) |-> (in_re != MOST_NEG));
    end
  endgenerate
endmodule

// File: rtl/r22_sdf_stage.sv
`timescale 1ns/1ps
module r22_sdf_stage #(
  parameter int N    = 16,
  parameter int IN_W = 12,
  localparam int OUT_W = IN_W + 2,
  localparam int CW    = $clog2(N)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_re,
  input  logic signed [IN_W-1:0]  in_im,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_re,
  output logic signed [OUT_W-1:0] out_im,
  output logic [CW-1:0]           frame_cnt
);
  logic                   s1_valid, s1_primed, s2_primed;
  logic signed [IN_W:0]   s1_re, s1_im;
  logic [CW-1:0]          s2_cnt;

  // first butterfly: half-frame feedback, no rotation
  r22_bf_unit #(.FRAME(N), .DEPTH(N/2), .IW(IN_W), .ROT(1'b0)) u_bf_half (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(s1_valid), .out_re(s1_re), .out_im(s1_im),
    .cnt(frame_cnt), .primed(s1_primed)
  );

  // second butterfly: quarter-frame feedback, -j on last quarter
  r22_bf_unit #(.FRAME(N), .DEPTH(N/4), .IW(IN_W+1), .ROT(1'b1)) u_bf_quarter (
    .clk(clk), .rst_n(rst_n), .in_valid(s1_valid), .in_re(s1_re), .in_im(s1_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
    .cnt(s2_cnt), .primed(s2_primed)
  );

  // second counter trails the first by half a frame plus any pending sample
  assert_stage_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_primed |-> (CW'(s2_cnt + CW'(s1_valid)) == CW'(frame_cnt + CW'(N/2))));
  assert_out_needs_prime_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> s2_primed);
endmodule

// File: tb/r22_sdf_stage_bench.sv
`timescale 1ns/1ps
module r22_sdf_stage_bench;
  localparam int N = 16, IW = 12, OW = IW + 2, CW = $clog2(N), Q = N / 4;
  localparam int MAXS = 5 * N;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic signed [IW-1:0] in_re = '0, in_im = '0;
  logic out_valid;
  logic signed [OW-1:0] out_re, out_im;
  logic [CW-1:0] frame_cnt;

  int stim_re [MAXS];
  int stim_im [MAXS];
  int cap_re [MAXS];
  int cap_im [MAXS];
  int cap_n = 0;
  int checks = 0, errors = 0;
  logic [15:0] lf = 16'hACE1;

  always #2.5 clk = ~clk;

  r22_sdf_stage #(.N(N), .IN_W(IW)) u_r22_sdf_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .frame_cnt(frame_cnt)
  );

  always @(negedge clk) begin
    if (!rst_n) cap_n = 0;
    else if (out_valid && cap_n < MAXS) begin
      cap_re[cap_n] = out_re;
      cap_im[cap_n] = out_im;
      cap_n++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // four-point transform of decimated quadruples, coefficient form
  function automatic int model(input int f, input int o, input bit want_im);
    int k = o % Q, g = o / Q, b = f * N + o % Q;
    int r0 = stim_re[b],     i0 = stim_im[b];
    int r1 = stim_re[b+Q],   i1 = stim_im[b+Q];
    int r2 = stim_re[b+2*Q], i2 = stim_im[b+2*Q];
    int r3 = stim_re[b+3*Q], i3 = stim_im[b+3*Q];
    int re, im;
    k = k;
    case (g)
      0: begin re = r0 + r1 + r2 + r3; im = i0 + i1 + i2 + i3; end
      1: begin re = r0 - r1 + r2 - r3; im = i0 - i1 + i2 - i3; end
      2: begin re = r0 + i1 - r2 - i3; im = i0 - r1 - i2 + r3; end
      default: begin re = r0 - i1 - r2 + i3; im = i0 + r1 - i2 - r3; end
    endcase
    return want_im ? im : re;
  endfunction

  function automatic int rnd12();
    lf = (lf >> 1) ^ ({16{lf[0]}} & 16'hB400);
    return int'(lf[11:0]) - 2048;
  endfunction

  task automatic clear_stim();
    for (int i = 0; i < MAXS; i++) begin stim_re[i] = 0; stim_im[i] = 0; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b1; in_re = 12'sd77; in_im = -12'sd5;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic drive(input int total, input bit gaps);
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_re = IW'(stim_re[i]); in_im = IW'(stim_im[i]);
      if (gaps && (i % 3 == 2)) begin
        int fc0;
        @(negedge clk);
        in_valid = 1'b0;
        fc0 = int'(frame_cnt);
        chk("R2", "count after accepted", fc0, (i + 1) % N);
        @(negedge clk);
        chk("R2", "count holds in gap", int'(frame_cnt), fc0);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp_frames(input int nf, input string req);
    chk(req, "enough outputs", int'(cap_n >= nf * N), 1);
    for (int o = 0; o < nf * N; o++) begin
      chk(req, "re", cap_re[o], model(o / N, o % N, 1'b0));
      chk(req, "im", cap_im[o], model(o / N, o % N, 1'b1));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b1; in_re = 12'sd300;
    repeat (2) @(negedge clk);
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    chk("R1", "out_re in reset", int'(out_re), 0);
    chk("R1", "out_im in reset", int'(out_im), 0);
    chk("R1", "frame_cnt in reset", int'(frame_cnt), 0);
    in_valid = 1'b0; rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", "idle count after reset", int'(frame_cnt), 0);
    chk("R3", "idle no valid", int'(out_valid), 0);
  endtask

  task automatic t_latency_impulse();
    int early = 0;
    clear_stim();
    stim_re[0] = 100; stim_im[0] = 37;
    do_reset();
    for (int c = 0; c < 2 * N; c++) begin
      @(negedge clk);
      if (c < 3 * N / 4 + 2 && out_valid) early++;
      if (c == 3 * N / 4 + 2) chk("R3", "first valid edge", int'(out_valid), 1);
      in_valid = 1'b1; in_re = IW'(stim_re[c]); in_im = IW'(stim_im[c]);
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3", "valid before latency", early, 0);
    cmp_frames(1, "R5 impulse");
  endtask

  task automatic t_dc();
    clear_stim();
    for (int i = 0; i < N; i++) begin stim_re[i] = 300; stim_im[i] = -150; end
    do_reset();
    drive(2 * N, 1'b0);
    cmp_frames(1, "R5 dc");
  endtask

  task automatic t_rotation();
    clear_stim();
    stim_re[Q+2] = 5; stim_im[3*Q+1] = 7; stim_re[2] = -3; stim_im[2] = 11;
    do_reset();
    drive(2 * N, 1'b0);
    cmp_frames(1, "R5 rotation");
  endtask

  task automatic t_extremes();
    clear_stim();
    for (int i = 0; i < N; i++) begin stim_re[i] = -2048; stim_im[i] = -2048; end
    for (int i = 0; i < N; i++) begin
      case (i / Q)
        0, 3:    begin stim_re[N+i] = 2047;  stim_im[N+i] = -2048; end
        default: begin stim_re[N+i] = -2048; stim_im[N+i] = 2047;  end
      endcase
    end
    do_reset();
    drive(3 * N, 1'b0);
    chk("R7", "full-scale dc real", cap_re[0], -8192);
    cmp_frames(2, "R7 R8 full scale");
  endtask

  task automatic t_stream();
    clear_stim();
    for (int i = 0; i < 3 * N; i++) begin stim_re[i] = rnd12(); stim_im[i] = rnd12(); end
    do_reset();
    drive(4 * N, 1'b0);
    chk("R6", "output count back to back", cap_n, 4 * N - 3 * N / 4);
    cmp_frames(3, "R6 back to back");
  endtask

  task automatic t_gaps();
    clear_stim();
    for (int i = 0; i < 2 * N; i++) begin stim_re[i] = rnd12(); stim_im[i] = rnd12(); end
    do_reset();
    drive(3 * N, 1'b1);
    chk("R4", "output count with gaps", cap_n, 3 * N - 3 * N / 4);
    cmp_frames(2, "R4 gaps");
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_latency_impulse();
    t_dc();
    t_rotation();
    t_extremes();
    t_stream();
    t_gaps();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule